// File: doc/BRIEF.md
# Synthesizer Mode Control Register

This block is a 32-bit control and status word for a frequency synthesizer. Software loads it through a byte-wide write port, one byte per clock, most significant byte first. The stored word changes only once the fourth byte has arrived. The writable fields are mode bits. Six of them go to the sweep and accumulator logic as dedicated outputs, and the low sixteen bits leave the block as a general mode bus.

One bit of the word is a read-only sticky flag. It is driven by a single unlock indication from the lock detector. The flag is set by any unlock seen while synchronization mode is active. It stays set after the loop locks again and is cleared only when the register is read. A read strobe captures the full word, including the flag, into a registered read port. The same strobe clears the flag, unless a new unlock arrives in that cycle.

Top module: `synth_ctrl_reg`

## Requirements
- R1: After a synchronous reset, every mode output is 0, and a read returns 0x00000000.
- R2: While `wr_en` is high, one byte is taken per clock, first byte to bits 31:24 and last byte to bits 7:0. The stored word and the mode outputs change on the clock edge that takes the fourth byte.
- R3: If `wr_en` falls before four bytes have been taken, the stored word is unchanged. The next write starts again at bits 31:24.
- R4: Bits 31:25 and 17:16 always read as 0, whatever was written to them.
- R5: Bit 24 ignores writes. It reads only the lock-loss flag.
- R6: The flag (bit 24) sets on any cycle in which `unlocked` and `sync_mode` are both high. An unlock while `sync_mode` is low leaves it clear.
- R7: Once set, the flag stays set after `unlocked` returns low, until a read. The read returns 1 and clears it, so a following read returns 0.
- R8: If an unlock (with `sync_mode` high) arrives in the same cycle as a read, that read returns the old flag value and the flag stays set afterwards.
- R9: Stored bits 23, 22, 21, 20, 19 and 18 drive `ramp_reload_upd`, `freq_acc_autoclr`, `phase_acc_autoclr`, `sine_select`, `freq_acc_hold` and `phase_acc_hold` respectively. Bits 15:0 drive `aux_mode`.
- R10: A read strobe makes `rd_valid` high for one cycle on the next clock and loads `rd_data`. `rd_data` holds its value until the next strobe.
- R11: If `wr_en` stays high past the fourth byte, the byte counter wraps. Each further group of four bytes commits a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write byte enable; low aborts a partial word |
| wr_byte | input | 8 | Write data byte, most significant first |
| rd_strobe | input | 1 | Read request; clears the lock-loss flag |
| sync_mode | input | 1 | Synchronization mode active |
| unlocked | input | 1 | Unlock indication from the lock detector |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 32 | Registered read word |
| ramp_reload_upd | output | 1 | Ramp countdown reload on update enable |
| freq_acc_autoclr | output | 1 | Frequency accumulator auto-clear enable |
| phase_acc_autoclr | output | 1 | Phase accumulator auto-clear enable |
| sine_select | output | 1 | Sine (1) or cosine (0) conversion |
| freq_acc_hold | output | 1 | Frequency accumulator clear-and-hold |
| phase_acc_hold | output | 1 | Phase accumulator clear-and-hold |
| aux_mode | output | 16 | Low mode bits |

## Verification
The bench builds the block with its defaults: a 32-bit word, 8-bit bytes and a four-step byte counter. That gives four bytes per word and a two-bit counter whose wrap is reached by an eight-byte stream. With the default writable mask, all-ones writes expose every reserved bit and the read-only flag position. Unlock pulses with synchronization mode on and off, placed before reads and on reads, cover the set, hold, clear and same-cycle cases of the flag.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int CTRL_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int FLAG_POS = 24;

  // Bit positions decoded by the sweep and accumulator logic
  localparam int POS_RAMP_RELOAD = 23;
  localparam int POS_FREQ_AUTO   = 22;
  localparam int POS_PHASE_AUTO  = 21;
  localparam int POS_SINE        = 20;
  localparam int POS_FREQ_HOLD   = 19;
  localparam int POS_PHASE_HOLD  = 18;
  localparam int AUX_W           = 16;

  // Writable mask: mode bits 23:18 and the low auxiliary field
  function automatic logic [CTRL_W-1:0] writable_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = POS_PHASE_HOLD; i <= POS_RAMP_RELOAD; i++) m[i] = 1'b1;
    for (int i = 0; i < AUX_W; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [CTRL_W-1:0] WR_MASK_DEFAULT = writable_mask();
endpackage

// File: rtl/scr_byte_collect.sv
module scr_byte_collect #(
  parameter int CTRL_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              commit,
  output logic [CTRL_W-1:0] word
);
  localparam int NUM_BYTES = CTRL_W / BYTE_W;
  localparam int CNT_W     = (NUM_BYTES > 2) ? $clog2(NUM_BYTES) : 1;
  localparam int HOLD_W    = CTRL_W - BYTE_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;

  // Counter restarts whenever the enable drops, discarding a partial word
  always_ff @(posedge clk) begin
    if (rst || !wr_en) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HOLD_W > BYTE_W) begin : g_shift_wide
      always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else if (wr_en) hold_q <= {hold_q[HOLD_W-BYTE_W-1:0], wr_byte};
      end
    end else begin : g_shift_narrow
      always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else if (wr_en) hold_q <= wr_byte[HOLD_W-1:0];
      end
    end
  endgenerate

  assign commit = wr_en && (cnt_q == LAST);
  assign word   = {hold_q, wr_byte};
endmodule

// File: rtl/scr_mode_store.sv
module scr_mode_store #(
  parameter int                CTRL_W  = 32,
  parameter logic [CTRL_W-1:0] WR_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [CTRL_W-1:0] word,
  output logic [CTRL_W-1:0] ctrl_q
);
  // One flop per writable bit; unused and read-only positions are tied low
  for (genvar g = 0; g < CTRL_W; g++) begin : g_bit
    if (WR_MASK[g]) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst) ctrl_q[g] <= 1'b0;
        else if (commit) ctrl_q[g] <= word[g];
      end
    end else begin : g_zero
      assign ctrl_q[g] = 1'b0;
    end
  end
endmodule

// File: rtl/scr_lock_flag.sv
module scr_lock_flag (
  input  logic clk,
  input  logic rst,
  input  logic sync_mode,
  input  logic unlocked,
  input  logic rd_clear,
  output logic flag_q
);
  logic event_now;
  assign event_now = sync_mode && unlocked;

  // A fresh event wins over a clearing read in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else flag_q <= (flag_q && !rd_clear) || event_now;
  end
endmodule

// File: rtl/synth_ctrl_reg.sv
module synth_ctrl_reg
  import synth_ctrl_pkg::*;
#(
  parameter logic [CTRL_W-1:0] WR_MASK = WR_MASK_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_strobe,
  input  logic              sync_mode,
  input  logic              unlocked,
  output logic              rd_valid,
  output logic [CTRL_W-1:0] rd_data,
  output logic              ramp_reload_upd,
  output logic              freq_acc_autoclr,
  output logic              phase_acc_autoclr,
  output logic              sine_select,
  output logic              freq_acc_hold,
  output logic              phase_acc_hold,
  output logic [AUX_W-1:0]  aux_mode
);
  localparam logic [CTRL_W-1:0] STORE_MASK = WR_MASK & ~(CTRL_W'(1) << FLAG_POS);

  logic              commit;
  logic [CTRL_W-1:0] word;
  logic [CTRL_W-1:0] ctrl_q;
  logic              lock_flag_q;
  logic [CTRL_W-1:0] rd_word;

  scr_byte_collect #(.CTRL_W(CTRL_W), .BYTE_W(BYTE_W)) u_collect (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .commit(commit), .word(word)
  );

  scr_mode_store #(.CTRL_W(CTRL_W), .WR_MASK(STORE_MASK)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .word(word), .ctrl_q(ctrl_q)
  );

  scr_lock_flag u_flag (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .unlocked(unlocked),
    .rd_clear(rd_strobe), .flag_q(lock_flag_q)
  );

  always_comb begin
    rd_word           = ctrl_q;
    rd_word[FLAG_POS] = lock_flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= rd_word;
    end
  end

  assign ramp_reload_upd   = ctrl_q[POS_RAMP_RELOAD];
  assign freq_acc_autoclr  = ctrl_q[POS_FREQ_AUTO];
  assign phase_acc_autoclr = ctrl_q[POS_PHASE_AUTO];
  assign sine_select       = ctrl_q[POS_SINE];
  assign freq_acc_hold     = ctrl_q[POS_FREQ_HOLD];
  assign phase_acc_hold    = ctrl_q[POS_PHASE_HOLD];
  assign aux_mode          = ctrl_q[AUX_W-1:0];
endmodule

// File: rtl/synth_ctrl_reg_chk.sv
module synth_ctrl_reg_chk #(
  parameter int CTRL_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_strobe,
  input logic              sync_mode,
  input logic              unlocked,
  input logic              rd_valid,
  input logic [CTRL_W-1:0] rd_data,
  input logic              flag,
  input logic [CTRL_W-1:0] ctrl
);
  // R6
  flag_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && unlocked) |=> flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !rd_strobe) |=> flag);

  // R7
  flag_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !(sync_mode && unlocked)) |=> !flag);

  // R3
  no_partial_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[31:25] == 7'd0) && (rd_data[17:16] == 2'd0));

  // R10
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_valid);

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> ($stable(rd_data) && !rd_valid));
endmodule

bind synth_ctrl_reg synth_ctrl_reg_chk #(.CTRL_W(synth_ctrl_pkg::CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_strobe(rd_strobe),
  .sync_mode(sync_mode), .unlocked(unlocked), .rd_valid(rd_valid),
  .rd_data(rd_data), .flag(lock_flag_q), .ctrl(ctrl_q)
);

// File: tb/synth_ctrl_reg_test.sv
module synth_ctrl_reg_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] MASK       = 32'h00FC_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        rd_strobe = 1'b0;
  logic        sync_mode = 1'b0;
  logic        unlocked = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        ramp_reload_upd, freq_acc_autoclr, phase_acc_autoclr;
  logic        sine_select, freq_acc_hold, phase_acc_hold;
  logic [15:0] aux_mode;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_reg  = '0;
  logic        model_flag = 1'b0;
  logic [31:0] last_read  = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_ctrl_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_strobe(rd_strobe), .sync_mode(sync_mode), .unlocked(unlocked),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ramp_reload_upd(ramp_reload_upd), .freq_acc_autoclr(freq_acc_autoclr),
    .phase_acc_autoclr(phase_acc_autoclr), .sine_select(sine_select),
    .freq_acc_hold(freq_acc_hold), .phase_acc_hold(phase_acc_hold),
    .aux_mode(aux_mode)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Mode outputs, packed as {aux, bit23..bit18}
  task automatic check_modes(input string tag);
    logic [31:0] act, exp;
    act = {10'd0, aux_mode, ramp_reload_upd, freq_acc_autoclr, phase_acc_autoclr,
           sine_select, freq_acc_hold, phase_acc_hold};
    exp = {10'd0, model_reg[15:0], model_reg[23:18]};
    check(act == exp, tag, act, exp);
  endtask

  task automatic write_bytes(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_byte = w[31-8*i -: 8];
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (n == 4) model_reg = w & MASK;
  endtask

  task automatic do_read(input string tag, input bit with_unlock);
    @(negedge clk);
    rd_strobe = 1'b1;
    if (with_unlock) begin
      sync_mode = 1'b1;
      unlocked  = 1'b1;
    end
    exp_q.push_back(model_reg | (32'(model_flag) << 24));
    tag_q.push_back(tag);
    last_read  = model_reg | (32'(model_flag) << 24);
    model_flag = with_unlock;
    @(negedge clk);
    rd_strobe = 1'b0;
    unlocked  = 1'b0;
  endtask

  task automatic unlock_pulse(input bit smode, input int n);
    @(negedge clk);
    sync_mode = smode;
    unlocked  = 1'b1;
    repeat (n) @(negedge clk);
    unlocked = 1'b0;
    if (smode) model_flag = 1'b1;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected rd_valid", rd_data, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rd_data == e, t, rd_data, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_modes("R1 reset modes");
    do_read("R1 reset read", 1'b0);

    // All ones: reserved and flag positions must stay low
    write_bytes(32'hFFFF_FFFF, 4);
    check_modes("R9 all modes set");
    do_read("R4 R5 all-ones readback", 1'b0);

    write_bytes(32'h0050_1234, 4);
    check_modes("R9 autoclr and sine");
    do_read("R2 byte order readback", 1'b0);

    // Partial write then a fresh full write
    write_bytes(32'hAAAA_AAAA, 3);
    check_modes("R3 partial write no change");
    do_read("R3 partial write readback", 1'b0);
    write_bytes(32'h0088_00FF, 4);
    check_modes("R3 restart after abort");
    do_read("R3 restart readback", 1'b0);

    // Unlock outside synchronization mode
    unlock_pulse(1'b0, 2);
    do_read("R6 unlock without sync", 1'b0);

    // Sticky over relock, cleared by read
    unlock_pulse(1'b1, 1);
    repeat (5) @(negedge clk);
    sync_mode = 1'b0;
    do_read("R7 flag after relock", 1'b0);
    do_read("R7 flag cleared by read", 1'b0);

    // Event coinciding with a read
    unlock_pulse(1'b1, 1);
    do_read("R8 read with concurrent event", 1'b1);
    sync_mode = 1'b0;
    do_read("R8 flag kept", 1'b0);
    do_read("R8 flag cleared", 1'b0);

    // Hold of read data
    repeat (3) @(negedge clk);
    check(rd_data == last_read && !rd_valid, "R10 rd_data hold", rd_data, last_read);

    // Continuous eight-byte stream
    begin
      logic [63:0] s;
      s = 64'h0004_0001_0008_0002;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (i == 4) begin
          model_reg = s[63:32] & MASK;
          check_modes("R11 first word committed");
        end
        wr_en   = 1'b1;
        wr_byte = s[63-8*i -: 8];
      end
      @(negedge clk);
      wr_en = 1'b0;
      model_reg = s[31:0] & MASK;
      check_modes("R11 second word committed");
      do_read("R11 stream readback", 1'b0);
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule